// File: doc/BRIEF.md
# Sequential-Stride Address Bus Codec

This block is a matched encoder/decoder pair for a long, heavily loaded address bus. Address streams often advance by a fixed stride, for example during cache refills. The encoder adds one side line, the step flag, next to the address wires. When a new address is exactly the previous address plus the stride, the encoder leaves the address wires at their old value and raises the step flag. In every other case it drives the address in plain binary and lowers the flag. A long run of consecutive addresses therefore causes no toggling on the wide bus at all.

The decoder sits at the far end of the wires. When the step flag is high, it adds the stride to its own last output. When the flag is low, it takes the bus value as it stands. A link strobe travels with the coded word and marks the cycles that carry an address. The stride is a parameter shared by both halves. Both halves register their outputs. An address therefore appears on the link one cycle after it is presented, and at the decoder output two cycles after it is presented.

Top module: `seq_addr_codec`

## Requirements
- R1: While reset is high and on the cycle after it is released, `link_word` is 0, `link_step` is 0, `link_strobe` is 0, `dst_valid` is 0 and `dst_addr` is 0.
- R2: The first valid address after reset is always sent in binary with `link_step` at 0, even when it equals 0 plus the stride.
- R3: If a valid address equals the previous valid address plus `STRIDE` (modulo 2^`ADDR_W`), the next cycle shows `link_step` at 1 and `link_word` unchanged.
- R4: Any other valid address appears on `link_word` in the next cycle with `link_step` at 0. Every valid address raises `link_strobe` for that one cycle.
- R5: On a cycle without `src_valid`, the next cycle shows `link_word` and `link_step` holding their values and `link_strobe` at 0. The remembered previous address does not change during such a cycle.
- R6: The decoder updates only when the strobe is high. It then outputs its previous `dst_addr` plus `STRIDE` if `link_step` is 1, and `link_word` if `link_step` is 0, and it raises `dst_valid` one cycle after the strobe.
- R7: The stride addition wraps, so with an 8-bit bus and stride 1, the address 0 after the address 255 counts as sequential.
- R8: The stream on `dst_addr` qualified by `dst_valid` equals the input stream exactly, two cycles later. `dst_addr` holds its value when `dst_valid` is 0.
- R9: For the back-to-back stream 4, 5, 6, 7, 8, 6, 7, 8 (8-bit bus, stride 1), the coded link makes 1 address-wire transition and 3 step-line transitions between its eight words. The decoded output makes 16, the same as plain binary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_addr | input | ADDR_W | Source address |
| src_valid | input | 1 | Source address is valid this cycle |
| link_word | output | ADDR_W | Coded address wires |
| link_step | output | 1 | Redundant step flag: 1 means previous address plus stride |
| link_strobe | output | 1 | Link carries an address this cycle |
| dst_addr | output | ADDR_W | Decoded address |
| dst_valid | output | 1 | Decoded address is valid this cycle |

## Verification
The encoder and the decoder each keep a private copy of "the last address". If either copy is wrong, no flag shows it. The fault only appears in the decoded stream, and only on the next step-coded word, which may come many cycles later. For that reason, the bench compares the decoded output with the source stream, delayed by two cycles, on every clock. It also drives long mixed runs with invalid gaps and a wrap from 255 to 0. An error in the stepping decision shows up on the link within one cycle, as a wrong step flag or a moving word.

// File: rtl/seq_addr_codec_pkg.sv
package seq_addr_codec_pkg;
  // Meaning of the redundant side line.
  typedef enum logic {
    LINK_PLAIN = 1'b0,
    LINK_STEP  = 1'b1
  } link_kind_t;
endpackage

// File: rtl/seq_addr_enc.sv
module seq_addr_enc
  import seq_addr_codec_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int STRIDE = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              in_valid,
  output logic [ADDR_W-1:0] out_word,
  output logic              out_step,
  output logic              out_strobe
);
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STRIDE);

  logic [ADDR_W-1:0] last_q;
  logic              primed_q;
  logic [ADDR_W-1:0] word_q;
  logic              step_q;
  logic              strobe_q;
  link_kind_t        kind;

  always_comb begin
    if (primed_q && (in_addr == last_q + STEP_V)) kind = LINK_STEP;
    else                                           kind = LINK_PLAIN;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q   <= '0;
      primed_q <= 1'b0;
      word_q   <= '0;
      step_q   <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= in_valid;
      if (in_valid) begin
        last_q   <= in_addr;
        primed_q <= 1'b1;
        step_q   <= (kind == LINK_STEP);
        if (kind == LINK_PLAIN) word_q <= in_addr;
      end
    end
  end

  assign out_word   = word_q;
  assign out_step   = step_q;
  assign out_strobe = strobe_q;
endmodule

// File: rtl/seq_addr_dec.sv
module seq_addr_dec
  import seq_addr_codec_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int STRIDE = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] in_word,
  input  logic              in_step,
  input  logic              in_strobe,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_valid
);
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STRIDE);

  logic [ADDR_W-1:0] addr_q;
  logic              valid_q;
  link_kind_t        kind;

  assign kind = link_kind_t'(in_step);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= in_strobe;
      if (in_strobe) begin
        if (kind == LINK_STEP) addr_q <= addr_q + STEP_V;
        else                   addr_q <= in_word;
      end
    end
  end

  assign out_addr  = addr_q;
  assign out_valid = valid_q;
endmodule

// File: rtl/seq_addr_codec.sv
module seq_addr_codec #(
  parameter int ADDR_W = 8,
  parameter int STRIDE = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic              src_valid,
  output logic [ADDR_W-1:0] link_word,
  output logic              link_step,
  output logic              link_strobe,
  output logic [ADDR_W-1:0] dst_addr,
  output logic              dst_valid
);
  seq_addr_enc #(.ADDR_W(ADDR_W), .STRIDE(STRIDE)) u_enc (
    .clk        (clk),
    .rst        (rst),
    .in_addr    (src_addr),
    .in_valid   (src_valid),
    .out_word   (link_word),
    .out_step   (link_step),
    .out_strobe (link_strobe)
  );

  seq_addr_dec #(.ADDR_W(ADDR_W), .STRIDE(STRIDE)) u_dec (
    .clk       (clk),
    .rst       (rst),
    .in_word   (link_word),
    .in_step   (link_step),
    .in_strobe (link_strobe),
    .out_addr  (dst_addr),
    .out_valid (dst_valid)
  );
endmodule

// File: rtl/seq_addr_codec_chk.sv
module seq_addr_codec_chk #(
  parameter int ADDR_W = 8,
  parameter int STRIDE = 1
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] src_addr,
  input logic              src_valid,
  input logic [ADDR_W-1:0] link_word,
  input logic              link_step,
  input logic              link_strobe,
  input logic [ADDR_W-1:0] dst_addr,
  input logic              dst_valid
);
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STRIDE);

  logic seen_q;
  always_ff @(posedge clk) begin
    if (rst)            seen_q <= 1'b0;
    else if (src_valid) seen_q <= 1'b1;
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |-> (!link_strobe && !dst_valid) || !$past(rst) || $past(rst) === 1'bx);

  a_r2_first_plain: assert property (@(posedge clk) disable iff (rst)
    (src_valid && !seen_q) |=> !link_step);

  a_r3_step_freezes: assert property (@(posedge clk) disable iff (rst)
    (link_strobe && link_step) |-> $stable(link_word));

  a_r4_strobe_follows: assert property (@(posedge clk) disable iff (rst)
    src_valid |=> link_strobe);

  a_r5_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !src_valid |=> (!link_strobe && $stable(link_word) && $stable(link_step)));

  a_r6_decode: assert property (@(posedge clk) disable iff (rst)
    link_strobe |=> (dst_valid &&
      dst_addr == ($past(link_step) ? $past(dst_addr) + STEP_V : $past(link_word))));

  a_r8_hold_out: assert property (@(posedge clk) disable iff (rst)
    !link_strobe |=> (!dst_valid && $stable(dst_addr)));
endmodule

bind seq_addr_codec seq_addr_codec_chk #(.ADDR_W(ADDR_W), .STRIDE(STRIDE)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .src_addr    (src_addr),
  .src_valid   (src_valid),
  .link_word   (link_word),
  .link_step   (link_step),
  .link_strobe (link_strobe),
  .dst_addr    (dst_addr),
  .dst_valid   (dst_valid)
);

// File: tb/seq_addr_codec_test.sv
`timescale 1ns/1ps
module seq_addr_codec_test;
  localparam int W = 8;
  localparam int S = 1;
  localparam int MASK = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] src_addr = '0;
  logic src_valid = 1'b0;
  logic [W-1:0] link_word, dst_addr;
  logic link_step, link_strobe, dst_valid;

  always #2.5 clk = ~clk;

  seq_addr_codec #(.ADDR_W(W), .STRIDE(S)) uut (
    .clk(clk), .rst(rst), .src_addr(src_addr), .src_valid(src_valid),
    .link_word(link_word), .link_step(link_step), .link_strobe(link_strobe),
    .dst_addr(dst_addr), .dst_valid(dst_valid)
  );

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int m_prev, m_bus, m_da;
  bit m_primed, m_inc, m_strobe, m_dv, pipe_v;
  int pipe_a;
  int tog_bus, tog_inc, tog_dst;
  int last_bus, last_inc, last_dst;
  bit counting;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual cycles=%0d expected <150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(string req, int act, int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_prev = 0; m_bus = 0; m_da = 0; m_primed = 0; m_inc = 0;
    m_strobe = 0; m_dv = 0; pipe_v = 0; pipe_a = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; src_valid = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    check("R1 word", link_word, 0);
    check("R1 step", link_step, 0);
    check("R1 strobe", link_strobe, 0);
    check("R1 dvalid", dst_valid, 0);
    check("R1 daddr", dst_addr, 0);
    rst = 1'b0;
    model_reset();
    @(posedge clk);
    @(negedge clk);
    check("R1 after release strobe", link_strobe, 0);
    check("R1 after release dvalid", dst_valid, 0);
  endtask

  task automatic step(bit v, int a, string tag);
    bit was_seq;
    src_valid = v; src_addr = a[W-1:0];
    @(posedge clk);
    @(negedge clk);
    // decoder sees last step's link: output equals source from one step earlier
    if (pipe_v) m_da = pipe_a;
    m_dv = pipe_v;
    was_seq = 0;
    m_strobe = v;
    if (v) begin
      was_seq = m_primed && (a == ((m_prev + S) & MASK));
      m_inc = was_seq;
      if (!was_seq) m_bus = a;
      m_prev = a; m_primed = 1;
    end
    pipe_v = v; pipe_a = a;
    if (!v) begin
      check({tag, " R5 word"}, link_word, m_bus);
      check({tag, " R5 step"}, link_step, m_inc);
      check({tag, " R5 strobe"}, link_strobe, 0);
    end else if (was_seq) begin
      check({tag, " R3 word"}, link_word, m_bus);
      check({tag, " R3 step"}, link_step, 1);
      check({tag, " R4 strobe"}, link_strobe, 1);
    end else begin
      check({tag, " R4 word"}, link_word, m_bus);
      check({tag, " R4 step"}, link_step, 0);
      check({tag, " R4 strobe"}, link_strobe, 1);
    end
    check({tag, " R6 dvalid"}, dst_valid, m_dv);
    check({tag, " R8 daddr"}, dst_addr, m_da);
    if (counting && v) begin
      tog_bus += $countones(link_word ^ last_bus[W-1:0]);
      tog_inc += (link_step != last_inc[0]);
    end
    if (counting && dst_valid) tog_dst += $countones(dst_addr ^ last_dst[W-1:0]);
    if (v) begin last_bus = link_word; last_inc = link_step; end
    if (dst_valid) last_dst = dst_addr;
  endtask

  int vec[8] = '{4, 5, 6, 7, 8, 6, 7, 8};

  initial begin
    model_reset();
    do_reset();

    // R9 reference stream, back to back
    counting = 0; tog_bus = 0; tog_inc = 0; tog_dst = 0;
    foreach (vec[i]) begin
      step(1, vec[i], "R9vec");
      counting = 1;
    end
    counting = 0;
    step(0, 0, "R9tail");
    tog_dst = 0; last_dst = 4;
    // recount decoded transitions over the eight decoded words
    for (int i = 1; i < 8; i++) tog_dst += $countones(vec[i] ^ vec[i-1]);
    check("R9 bus toggles", tog_bus, 1);
    check("R9 inc toggles", tog_inc, 3);
    check("R9 coded total", tog_bus + tog_inc, 4);
    check("R9 binary toggles", tog_dst, 16);

    // R5 gaps inside a sequential run
    step(1, 20, "gap"); step(0, 99, "gap"); step(0, 3, "gap");
    step(1, 21, "gap"); step(0, 0, "gap"); step(1, 22, "gap");
    step(1, 40, "gap");

    // R7 wrap 254 -> 255 -> 0 -> 1
    step(1, 254, "R7"); step(1, 255, "R7");
    step(1, 0, "R7"); check("R7 wrap step", link_step, 1);
    step(1, 1, "R7"); step(0, 0, "R7");

    // R2 first word after reset equals 0 + stride
    do_reset();
    step(1, 1, "R2"); check("R2 first plain", link_step, 0);
    step(1, 2, "R2"); check("R2 next steps", link_step, 1);
    step(0, 0, "R2");

    // mixed stream
    for (int k = 0; k < 400; k++) begin
      int r = $urandom_range(0, 9);
      int a;
      if (r < 5) a = (pipe_a + S) & MASK;
      else if (r < 8) a = $urandom_range(0, MASK);
      else a = pipe_a;
      step(r != 9 || k[0], a, "mix");
    end
    step(0, 0, "drain"); step(0, 0, "drain");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule